// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit sits between the memory stage of a processor pipeline and a data memory that is 32 bits wide and addressed by word. On the request side it takes a byte address, an access size, a signedness flag, a store flag, store data and a run-time endianness select. For every request that is correctly aligned, it produces the word address, a byte-enable mask and the store data moved into the enabled byte lanes. A load has a read latency of one cycle. The unit keeps the context of the load: the lane offset, the size, the sign mode and the endianness. When the memory word returns, the unit selects the addressed byte, half-word or word, puts it in the correct order and extends it to 32 bits.

An access that breaks the alignment rule raises a fault in the same cycle. The unit then disables the memory access completely and never produces a load result, so the pipeline can trap without a partial write. A parameter adds an optional output register on the load result.

Byte lane k of the memory word is bits [8k+7:8k]. It holds the byte at address offset k inside the word.

Top module: `lsu_lane_align`

## Requirements
- R1: `mem_addr` equals `req_addr` shifted right by two, in the same cycle as the request.
- R2: Size codes are 0 for byte, 1 for half-word, 2 for word and 3 for reserved. For an accepted request, `mem_be` has one bit set at the offset for a byte, bits offset and offset+1 set for a half-word, and all four bits set for a word. `mem_en` is high and `mem_we` equals `req_store`.
- R3: When `big_endian` is 0, a store places the least significant byte of `req_wdata` in the lane at the lowest address of the access. Each next byte goes into the next higher lane. Lanes that are not enabled carry zero.
- R4: When `big_endian` is 1, a store places the most significant byte of the accessed value (bits 31:24 for a word, bits 15:8 for a half-word) in the lowest lane of the access. For example, storing word 0x114488FF at offset 0 gives `mem_wdata` 0xFF884411. Unused lanes carry zero.
- R5: A word access faults unless address bits [1:0] are 00. A half-word access faults when address bit 0 is 1. A byte access never faults. The reserved size code always faults. `misalign_fault` is high only in the cycle of a valid request that breaks these rules.
- R6: On a fault, `mem_en`, `mem_we` and every bit of `mem_be` are low. A faulting load produces no `load_valid`.
- R7: When `req_signed` is 1, a byte load or half-word load copies the top bit of the selected field into every upper bit. For example, a big-endian signed byte load at offset 3 of `mem_rdata` 0xFF884411 returns 0xFFFFFFFF.
- R8: When `req_signed` is 0, a sub-word load fills the upper bits with zero. For example, a big-endian unsigned byte load at offset 3 of `mem_rdata` 0xFF884411 returns 0x000000FF. A word load returns the four lanes with no extension: lane order when little-endian, lanes reversed when big-endian.
- R9: With `LOAD_REG` = 0, `load_valid` and `load_data` appear in the cycle after an accepted load. The data is built from `mem_rdata` of that cycle, using the size, sign mode, offset and endianness that were given with the request. With `LOAD_REG` = 1, they appear one cycle later.
- R10: While reset is active, and in the first cycle after reset, `load_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 reserved |
| req_signed | input | 1 | Load extends the sign when 1, fills with zero when 0 |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store value, right-aligned |
| big_endian | input | 1 | 1 = lowest address holds the most significant byte |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Store data moved into its lanes |
| mem_rdata | input | 32 | Word read from memory, one cycle after the request |
| misalign_fault | output | 1 | Alignment fault for the current request |
| load_valid | output | 1 | Load result valid |
| load_data | output | 32 | Load result after extension |

## Verification
The bench targets the following corner cases:
- The highest lane offset (3), where a byte taken from the wrong lane or a lane index counted the wrong way shows as a swapped byte.
- Half-words at offset 2 in both endian orders, where a design that ignored endianness returns the two bytes swapped.
- Sign extension of fields whose top bit is set, where mixing up signed and unsigned loads returns a value with the wrong upper bits.
- Misaligned word and half-word addresses and the reserved size code. A design that does not suppress the access here would leave byte enables on, or would report a load result for an access that raised a fault.
- A store followed by a load with the opposite endianness, which shows whether the load used the endianness captured with the request or the current input.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

  localparam int LANES  = 4;
  localparam int DATA_W = 8 * LANES;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef struct packed {
    acc_size_e  size;
    logic [1:0] off;
    logic       sgn;
    logic       big;
  } load_ctx_t;

  function automatic int size_bytes(acc_size_e s);
    case (s)
      SZ_BYTE: return 1;
      SZ_HALF: return 2;
      default: return LANES;
    endcase
  endfunction

  function automatic logic misaligned(acc_size_e s, logic [1:0] off);
    case (s)
      SZ_BYTE: return 1'b0;
      SZ_HALF: return off[0];
      SZ_WORD: return |off;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [LANES-1:0] lane_mask(acc_size_e s, logic [1:0] off);
    logic [LANES-1:0] m;
    int o;
    int nb;
    o  = int'(off);
    nb = size_bytes(s);
    for (int lane = 0; lane < LANES; lane++)
      m[lane] = (lane >= o) && (lane < o + nb);
    return m;
  endfunction

  // lane number that carries value byte i (i = 0 is least significant)
  function automatic int lane_of(int i, int nb, int o, logic big);
    return big ? (o + nb - 1 - i) : (o + i);
  endfunction

  function automatic logic [DATA_W-1:0] steer_store(acc_size_e s, logic [1:0] off,
                                                    logic big, logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] w;
    int nb;
    int lane;
    w  = '0;
    nb = size_bytes(s);
    for (int i = 0; i < LANES; i++) begin
      lane = lane_of(i, nb, int'(off), big);
      if (i < nb && lane >= 0 && lane < LANES)
        w[8*lane +: 8] = d[8*i +: 8];
    end
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] extract_load(acc_size_e s, logic [1:0] off,
                                                     logic big, logic sgn,
                                                     logic [DATA_W-1:0] w);
    logic [DATA_W-1:0] v;
    logic top;
    int nb;
    int lane;
    v   = '0;
    top = 1'b0;
    nb  = size_bytes(s);
    for (int i = 0; i < LANES; i++) begin
      lane = lane_of(i, nb, int'(off), big);
      if (i < nb && lane >= 0 && lane < LANES) begin
        v[8*i +: 8] = w[8*lane +: 8];
        top         = w[8*lane + 7];
      end
    end
    for (int i = 0; i < LANES; i++)
      if (i >= nb && sgn && top) v[8*i +: 8] = 8'hFF;
    return v;
  endfunction

endpackage

// File: rtl/lsu_req_decode.sv
module lsu_req_decode
  import lsu_align_pkg::*;
(
  input  logic             req_valid,
  input  acc_size_e        size,
  input  logic [1:0]       off,
  output logic             fault,
  output logic             en,
  output logic [LANES-1:0] be
);
  logic bad_align;

  always_comb begin
    bad_align = misaligned(size, off);
    fault     = req_valid & bad_align;
    en        = req_valid & ~bad_align;
    be        = en ? lane_mask(size, off) : '0;
  end
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
  import lsu_align_pkg::*;
(
  input  acc_size_e         size,
  input  logic [1:0]        off,
  input  logic              big,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out
);
  always_comb data_out = steer_store(size, off, big, data_in);
endmodule

// File: rtl/lsu_load_track.sv
module lsu_load_track
  import lsu_align_pkg::*;
#(
  parameter bit LOAD_REG = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  load_ctx_t         ctx_in,
  input  logic [DATA_W-1:0] rdata,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  load_ctx_t         ctx_q;
  logic              pend_q;
  logic [DATA_W-1:0] ext_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ctx_q  <= '0;
    end else begin
      pend_q <= accept;
      if (accept) ctx_q <= ctx_in;
    end
  end

  always_comb ext_data = extract_load(ctx_q.size, ctx_q.off, ctx_q.big, ctx_q.sgn, rdata);

  generate
    if (LOAD_REG) begin : g_out_reg
      logic              v_q;
      logic [DATA_W-1:0] d_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q <= 1'b0;
          d_q <= '0;
        end else begin
          v_q <= pend_q;
          if (pend_q) d_q <= ext_data;
        end
      end
      assign out_valid = v_q;
      assign out_data  = d_q;
    end else begin : g_out_comb
      assign out_valid = pend_q;
      assign out_data  = ext_data;
    end
  endgenerate
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
  import lsu_align_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter bit LOAD_REG = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic              big_endian,
  output logic [ADDR_W-3:0] mem_addr,
  output logic              mem_en,
  output logic              mem_we,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              misalign_fault,
  output logic              load_valid,
  output logic [31:0]       load_data
);
  localparam int OFF_W = $clog2(LANES);

  acc_size_e        acc_size;
  logic [OFF_W-1:0] acc_off;
  logic             acc_go;
  logic             ld_accept;
  load_ctx_t        ld_ctx;

  assign acc_size = acc_size_e'(req_size);
  assign acc_off  = req_addr[OFF_W-1:0];
  assign mem_addr = req_addr[ADDR_W-1:OFF_W];

  lsu_req_decode u_dec (
    .req_valid (req_valid),
    .size      (acc_size),
    .off       (acc_off),
    .fault     (misalign_fault),
    .en        (acc_go),
    .be        (mem_be)
  );

  assign mem_en    = acc_go;
  assign mem_we    = acc_go & req_store;
  assign ld_accept = acc_go & ~req_store;

  lsu_store_steer u_st (
    .size     (acc_size),
    .off      (acc_off),
    .big      (big_endian),
    .data_in  (req_wdata),
    .data_out (mem_wdata)
  );

  always_comb begin
    ld_ctx.size = acc_size;
    ld_ctx.off  = acc_off;
    ld_ctx.sgn  = req_signed;
    ld_ctx.big  = big_endian;
  end

  lsu_load_track #(.LOAD_REG(LOAD_REG)) u_ld (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (ld_accept),
    .ctx_in    (ld_ctx),
    .rdata     (mem_rdata),
    .out_valid (load_valid),
    .out_data  (load_data)
  );
endmodule

// File: rtl/lsu_lane_align_chk.sv
module lsu_lane_align_chk #(
  parameter bit LOAD_REG = 1'b0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_store,
  input logic [1:0] req_size,
  input logic [1:0] addr_lo,
  input logic       mem_en,
  input logic       mem_we,
  input logic [3:0] mem_be,
  input logic       misalign_fault,
  input logic       load_valid
);
  logic ld_taken;
  assign ld_taken = mem_en & ~mem_we;

  AST_FAULT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_fault |-> req_valid); // R5

  AST_ALIGNED_WORD_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'd2 && addr_lo == 2'b00) |-> !misalign_fault); // R5

  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_fault |-> (mem_be == 4'b0000 && !mem_en && !mem_we)); // R6

  AST_BE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> ($countones(mem_be) == ((req_size == 2'd0) ? 1 : (req_size == 2'd1) ? 2 : 4))); // R2

  AST_BE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_en |-> (mem_be == 4'b0000)); // R2

  generate
    if (LOAD_REG) begin : g_lat2
      AST_LOAD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid |-> $past(ld_taken, 2)); // R9
    end else begin : g_lat1
      AST_LOAD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid |-> $past(ld_taken)); // R9
      AST_LOAD_ARRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ld_taken)) |-> load_valid); // R9
    end
  endgenerate
endmodule

bind lsu_lane_align lsu_lane_align_chk #(.LOAD_REG(LOAD_REG)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_store      (req_store),
  .req_size       (req_size),
  .addr_lo        (req_addr[1:0]),
  .mem_en         (mem_en),
  .mem_we         (mem_we),
  .mem_be         (mem_be),
  .misalign_fault (misalign_fault),
  .load_valid     (load_valid)
);

// File: tb/tb_lsu_lane_align.sv
`timescale 1ns/1ps
module tb_lsu_lane_align;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0, req_signed = 1'b0, big_endian = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = '0, req_wdata = '0, mem_rdata = '0;
  logic [29:0] mem_addr;
  logic        mem_en, mem_we, misalign_fault, load_valid;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, load_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  lsu_lane_align dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] bswap32(logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  function automatic bit bad(logic [1:0] sz, logic [1:0] a);
    if (sz == 2'd3) return 1'b1;
    if (sz == 2'd2) return a != 2'b00;
    if (sz == 2'd1) return a[0];
    return 1'b0;
  endfunction

  function automatic logic [3:0] exp_be(logic [1:0] sz, logic [1:0] a);
    case (sz)
      2'd0: return 4'b0001 << a;
      2'd1: return 4'b0011 << a;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] exp_store(logic [1:0] sz, logic [1:0] a, logic be, logic [31:0] d);
    case (sz)
      2'd0: return {24'd0, d[7:0]} << (8 * a);
      2'd1: return (be ? {16'd0, d[7:0], d[15:8]} : {16'd0, d[15:0]}) << (8 * a);
      default: return be ? bswap32(d) : d;
    endcase
  endfunction

  function automatic logic [31:0] exp_load(logic [1:0] sz, logic [1:0] a, logic be, logic s,
                                           logic [31:0] w);
    logic [31:0] sh;
    sh = w >> (8 * a);
    case (sz)
      2'd0: return s ? {{24{sh[7]}}, sh[7:0]} : {24'd0, sh[7:0]};
      2'd1: begin
        logic [15:0] h;
        h = be ? {sh[7:0], sh[15:8]} : sh[15:0];
        return s ? {{16{h[15]}}, h} : {16'd0, h};
      end
      default: return be ? bswap32(w) : w;
    endcase
  endfunction

  task automatic do_store(logic [1:0] sz, logic [31:0] a, logic be, logic [31:0] d);
    bit f;
    @(negedge clk);
    req_valid = 1; req_store = 1; req_size = sz; req_addr = a; big_endian = be;
    req_wdata = d; req_signed = 0;
    #1;
    f = bad(sz, a[1:0]);
    chk("R1 mem_addr", {2'b00, mem_addr}, a >> 2);
    chk("R5 fault", {31'd0, misalign_fault}, {31'd0, f});
    if (f) begin
      chk("R6 quiet on fault", {26'd0, mem_en, mem_we, mem_be}, 32'd0);
    end else begin
      chk("R2 be/en/we", {26'd0, mem_en, mem_we, mem_be}, {26'd0, 2'b11, exp_be(sz, a[1:0])});
      chk(be ? "R4 store lanes" : "R3 store lanes", mem_wdata, exp_store(sz, a[1:0], be, d));
    end
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic do_load(logic [1:0] sz, logic [31:0] a, logic be, logic s, logic [31:0] w);
    bit f;
    @(negedge clk);
    req_valid = 1; req_store = 0; req_size = sz; req_addr = a; big_endian = be;
    req_signed = s; req_wdata = $urandom;
    #1;
    f = bad(sz, a[1:0]);
    chk("R5 fault", {31'd0, misalign_fault}, {31'd0, f});
    if (f) chk("R6 quiet on fault", {26'd0, mem_en, mem_we, mem_be}, 32'd0);
    else   chk("R2 load be", {26'd0, mem_en, mem_we, mem_be}, {26'd0, 2'b10, exp_be(sz, a[1:0])});
    @(negedge clk);
    req_valid = 0; mem_rdata = w;
    big_endian = ~be; req_signed = ~s; req_size = $urandom; req_addr = $urandom;
    #1;
    if (f) begin
      chk("R6 no result after fault", {31'd0, load_valid}, 32'd0);
    end else begin
      chk("R9 load_valid", {31'd0, load_valid}, 32'd1);
      chk(s ? "R7 signed load" : "R8 unsigned load", load_data, exp_load(sz, a[1:0], be, s, w));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    #1;
    chk("R10 load_valid in reset", {31'd0, load_valid}, 32'd0);
    chk("R2 idle be in reset", {28'd0, mem_be}, 32'd0);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk("R10 load_valid after reset", {31'd0, load_valid}, 32'd0);

    // directed corners
    do_store(2'd2, 32'h0, 1'b1, 32'h114488FF);          // R4 example
    do_store(2'd2, 32'h0, 1'b0, 32'h114488FF);          // R3 example
    do_store(2'd1, 32'h6, 1'b1, 32'h0000A55A);          // R4 half at offset 2
    do_store(2'd0, 32'h3, 1'b0, 32'h000000C3);          // R3 top lane
    do_store(2'd2, 32'h2, 1'b0, 32'hDEADBEEF);          // R5/R6 misaligned word
    do_store(2'd3, 32'h0, 1'b0, 32'hDEADBEEF);          // R5 reserved size
    do_load(2'd0, 32'h0, 1'b1, 1'b1, 32'hFF884411);     // R7 -> 00000011
    do_load(2'd0, 32'h3, 1'b1, 1'b1, 32'hFF884411);     // R7 -> FFFFFFFF
    do_load(2'd0, 32'h3, 1'b1, 1'b0, 32'hFF884411);     // R8 -> 000000FF
    do_load(2'd1, 32'h2, 1'b1, 1'b1, 32'h80FF0000);     // R7 half BE
    do_load(2'd1, 32'h2, 1'b0, 1'b1, 32'h80FF0000);     // R7 half LE
    do_load(2'd2, 32'h8, 1'b1, 1'b0, 32'h11223344);     // R8 word BE
    do_load(2'd1, 32'h1, 1'b0, 1'b0, 32'h12345678);     // R6 misaligned half
    do_load(2'd3, 32'h4, 1'b0, 1'b1, 32'h12345678);     // R6 reserved size

    for (int k = 0; k < 400; k++) begin
      if ($urandom_range(1, 0) == 1)
        do_store(2'($urandom_range(3, 0)), $urandom, 1'($urandom), $urandom);
      else
        do_load(2'($urandom_range(3, 0)), $urandom, 1'($urandom), 1'($urandom), $urandom);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule